// File: doc/BRIEF.md
# Chained Software Reset Sequencer

This block drives the resets of a processor subsystem from three software control bits. Each bit holds one reset stage. While a bit is 1 its reset output stays asserted. When software writes it to 0, a per-stage timer runs for a programmable number of clock cycles and then releases that stage's reset. The middle stage is a two-step chain. Its timer releases a power-on reset to the subsystem. The subsystem then runs its own initialization and raises a done signal. Only after that does the stage's own reset drop.

Each release sets a sticky status bit. Software reads the status bits and clears them by writing ones. A flat register port gives write access and a combinational read path to the control word, the status word and the three timeout values. All reset outputs are active high: 1 means the reset is asserted.

Register addresses: 0 holds the control word (bit 0 first stage, bit 1 second stage, bit 2 third stage, reset value 1 each). Address 1 holds the status word (bit 8 first stage, bit 9 second stage, bit 10 third stage). Addresses 2, 3 and 4 hold the 8-bit timeouts of the first, second and third stage. Every unlisted bit and address reads 0.

Top module: `rst_seq_top`

## Requirements
- R1: After reset all four reset outputs are 1, the control word reads 3'b111, the status word reads 0 and each timeout register reads the parameter TMO_INIT (default 2).
- R2: A write that clears control bit 0 at clock edge k, with the first-stage timeout at N, releases `stg1_rst` at edge k+1+N and sets status bit 8 at that same edge.
- R3: A write that clears control bit 1 at edge k, with the second-stage timeout at N, releases `por_rst` at edge k+1+N, while `stg2_rst` stays 1.
- R4: Once `por_rst` is 0, `stg2_rst` drops at the first edge where `sub_done` is sampled 1, and status bit 9 is set at that same edge. With `sub_done` low it waits with no time limit.
- R5: A `sub_done` sampled 1 while `por_rst` is still 1 is not remembered and never releases `stg2_rst`.
- R6: A write that clears control bit 2 at edge k, with the third-stage timeout at N, releases `stg3_rst` at edge k+1+N and sets status bit 10 at that same edge.
- R7: A timeout value of 0 releases the stage at the edge right after the clearing write (k+1).
- R8: Writing a control bit back to 1 asserts that stage's outputs right after the write edge (for bit 1, both `por_rst` and `stg2_rst`) and aborts its timer. A later clear restarts the full timeout.
- R9: Status bits stay set until a write to address 1 carries a 1 in their position. Writing 0 there leaves them unchanged.
- R10: When a release and a clearing write to the same status bit fall on one edge, the bit ends up set.
- R11: The timeout is captured when the timer starts. Rewriting the timeout register during a count does not change that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| sub_done | input | 1 | Initialization done from the subsystem |
| por_rst | output | 1 | Power-on reset to the subsystem, 1 = asserted |
| stg1_rst | output | 1 | First-stage reset, 1 = asserted |
| stg2_rst | output | 1 | Second-stage reset, 1 = asserted |
| stg3_rst | output | 1 | Third-stage reset, 1 = asserted |

## Verification
The bench counts the edges from each clearing write to the release, for timeouts of 0, 1 and larger values. A counter with an off-by-one error, or one that treats 0 as 256, shows up at the exact release cycle. A done pulse sent before the power-on release tests that the design does not latch it. A design that did latch it would drop the second-stage reset as soon as the power-on reset fell. A long idle wait with done low tests that the handshake has no hidden time limit. Further cases cover: an abort in the middle of a count followed by a full restart, a timeout rewrite during a count, and a status clear that lands on the release edge, where a design that gives the clear priority would lose the event.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and state type for the reset sequencer.
// Assumes three stages, with the handshake on the middle one.
package rst_seq_pkg;
    localparam int NUM_STAGES = 3;
    localparam int HS_STAGE   = 1;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_STAT  = 1;
    localparam int ADDR_TMO0  = 2;
    localparam int STAT_LSB   = 8;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WAIT  = 2'd2,
        ST_REL   = 2'd3
    } stage_st_e;
endpackage

// File: rtl/rst_seq_regs.sv
`timescale 1ns/1ps
// Module: register file of the reset sequencer.
// Holds the control bits (reset to 1), the sticky write-one-to-clear status
// bits and one timeout register per stage. Reads are combinational.
// Assumes DATA_W is wide enough for the status field and for the timeout.
module rst_seq_regs
    import rst_seq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 16,
    parameter int TMO_W    = 8,
    parameter int TMO_INIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [NUM_STAGES-1:0] rel_set_i,
    output logic [NUM_STAGES-1:0] ctrl_o,
    output logic [TMO_W-1:0]      tmo_o [NUM_STAGES],
    output logic [DATA_W-1:0]     rdata_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    logic [NUM_STAGES-1:0] ctrl_q;
    logic [NUM_STAGES-1:0] stat_q;
    logic [NUM_STAGES-1:0] stat_clr;
    logic [TMO_W-1:0]      tmo_q [NUM_STAGES];
    logic                  unused_wdata;

    assign unused_wdata = ^wdata_i;

    // Control bits: write the low bits of the data at the control address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '1;
        else if (wr_i && addr_i == A_CTRL)
            ctrl_q <= wdata_i[NUM_STAGES-1:0];
    end

    // Status clear mask: ones written to the status field.
    always_comb begin
        stat_clr = '0;
        if (wr_i && addr_i == A_STAT)
            stat_clr = wdata_i[STAT_LSB +: NUM_STAGES];
    end

    // Status bits: a release sets the bit and wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~stat_clr) | rel_set_i;
    end

    // One timeout register per stage, at consecutive addresses.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_tmo
        localparam logic [ADDR_W-1:0] A_TMO = ADDR_W'(ADDR_TMO0 + i);

        // Timeout register for stage i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tmo_q[i] <= TMO_W'(TMO_INIT);
            else if (wr_i && addr_i == A_TMO)
                tmo_q[i] <= wdata_i[TMO_W-1:0];
        end
        assign tmo_o[i] = tmo_q[i];

        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !(wr_i && addr_i == A_STAT && wdata_i[STAT_LSB+i])) |=> stat_q[i]) // R9
            else $error("status bit %0d lost without a clear", i);
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            rel_set_i[i] |=> stat_q[i]) // R10
            else $error("status bit %0d not set on release", i);
    end

    // Read mux over control, status and timeout registers.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL) begin
            rdata_o[NUM_STAGES-1:0] = ctrl_q;
        end else if (addr_i == A_STAT) begin
            rdata_o[STAT_LSB +: NUM_STAGES] = stat_q;
        end else begin
            for (int j = 0; j < NUM_STAGES; j++) begin
                if (addr_i == ADDR_W'(ADDR_TMO0 + j))
                    rdata_o[TMO_W-1:0] = tmo_q[j];
            end
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rst_seq_stage.sv
`timescale 1ns/1ps
// Module: one reset stage. A cleared hold input starts a timer loaded from
// tmo_i. When the timer expires the stage releases. With HANDSHAKE set, the
// expiry releases only the early (power-on) output, and the main output then
// waits for done_i. Done is looked at only in the wait state. A raised hold
// input forces the stage back to its held state at once.
// Assumes hold_i and tmo_i come from registers in the same clock domain.
module rst_seq_stage
    import rst_seq_pkg::*;
#(
    parameter int TMO_W     = 8,
    parameter bit HANDSHAKE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic             done_i,
    output logic             rst_o,
    output logic             pre_rst_o,
    output logic             rel_pulse_o
);
    localparam stage_st_e EXPIRE_ST = HANDSHAKE ? ST_WAIT : ST_REL;

    stage_st_e        st_q, st_d;
    logic [TMO_W-1:0] cnt_q, cnt_d;

    // Next state and counter: load on start, count down, wait, release.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (hold_i) begin
            st_d  = ST_HOLD;
            cnt_d = '0;
        end else begin
            case (st_q)
                ST_HOLD: begin
                    if (tmo_i == '0) begin
                        st_d = EXPIRE_ST;
                    end else begin
                        st_d  = ST_COUNT;
                        cnt_d = tmo_i - TMO_W'(1);
                    end
                end
                ST_COUNT: begin
                    if (cnt_q == '0)
                        st_d = EXPIRE_ST;
                    else
                        cnt_d = cnt_q - TMO_W'(1);
                end
                ST_WAIT: begin
                    if (done_i)
                        st_d = ST_REL;
                end
                default: st_d = ST_REL;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign rst_o       = hold_i || (st_q != ST_REL);
    assign rel_pulse_o = (st_d == ST_REL) && (st_q != ST_REL);

    if (HANDSHAKE) begin : g_hs
        assign pre_rst_o = hold_i || (st_q == ST_HOLD) || (st_q == ST_COUNT);

        AST_DONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rst_o) |-> $past(done_i)) // R4
            else $error("second stage released without done");
        AST_EARLY_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_HOLD || st_q == ST_COUNT) |=> (st_q != ST_REL)) // R5
            else $error("stage released before the power-on release");
    end else begin : g_plain
        assign pre_rst_o = rst_o;

        AST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            st_q != ST_WAIT) // R2
            else $error("plain stage entered the wait state");
    end

    AST_HOLD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q == ST_HOLD)) // R8
        else $error("hold did not abort the stage");
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && !hold_i && cnt_q != '0)
        |=> (st_q == ST_COUNT && cnt_q == $past(cnt_q) - TMO_W'(1))) // R11
        else $error("timer did not step by one");
endmodule

// File: rtl/rst_seq_top.sv
`timescale 1ns/1ps
// Module: top of the chained software reset sequencer. Connects the register
// file to three stages. The middle stage carries the done handshake and
// supplies the power-on reset output.
// Assumes sub_done is synchronous to clk.
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 16,
    parameter int TMO_W    = 8,
    parameter int TMO_INIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sub_done,
    output logic              por_rst,
    output logic              stg1_rst,
    output logic              stg2_rst,
    output logic              stg3_rst
);
    logic [NUM_STAGES-1:0] ctrl;
    logic [NUM_STAGES-1:0] rel_set;
    logic [NUM_STAGES-1:0] stg_rst;
    logic [NUM_STAGES-1:0] pre_rst;
    logic [TMO_W-1:0]      tmo [NUM_STAGES];
    logic                  unused_pre;

    rst_seq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W), .TMO_INIT(TMO_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rel_set_i(rel_set), .ctrl_o(ctrl),
        .tmo_o(tmo), .rdata_o(reg_rdata)
    );

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        rst_seq_stage #(
            .TMO_W(TMO_W), .HANDSHAKE(i == HS_STAGE)
        ) u_stage (
            .clk(clk), .rst_n(rst_n), .hold_i(ctrl[i]), .tmo_i(tmo[i]),
            .done_i(sub_done), .rst_o(stg_rst[i]), .pre_rst_o(pre_rst[i]),
            .rel_pulse_o(rel_set[i])
        );
    end

    assign unused_pre = ^pre_rst;
    assign por_rst    = pre_rst[HS_STAGE];
    assign stg1_rst   = stg_rst[0];
    assign stg2_rst   = stg_rst[1];
    assign stg3_rst   = stg_rst[2];

    AST_POR_BEFORE_STG2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stg2_rst) |-> (!por_rst)) // R4
        else $error("second stage out of reset while power-on reset held");
endmodule

// File: tb/rst_seq_top_bench.sv
`timescale 1ns/1ps
module rst_seq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sub_done = 1'b0;
    logic        por_rst, stg1_rst, stg2_rst, stg3_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [2:0] ctl_sh = 3'b111;

    rst_seq_top u_rst_seq_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sub_done(sub_done),
        .por_rst(por_rst), .stg1_rst(stg1_rst), .stg2_rst(stg2_rst),
        .stg3_rst(stg3_rst)
    );

    always #2 clk = ~clk;

    // stage index [9:8], timeout [7:0]
    localparam logic [9:0] VEC [6] = '{
        {2'd0, 8'd0}, {2'd0, 8'd1}, {2'd0, 8'd5},
        {2'd2, 8'd3}, {2'd2, 8'd0}, {2'd2, 8'd7}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic out_of(input int idx);
        return (idx == 0) ? stg1_rst : stg3_rst;
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 outputs", {12'd0, por_rst, stg1_rst, stg2_rst, stg3_rst}, 16'h000f);
        rd(0, d); check("R1 ctrl", d, 16'h0007);
        rd(1, d); check("R1 status", d, 16'h0000);
        for (int a = 2; a < 5; a++) begin
            rd(3'(a), d); check("R1 tmo", d, 16'h0002);
        end
        @(negedge clk);

        // Table of timing vectors for stages 1 and 3
        for (int v = 0; v < 6; v++) begin
            int idx;
            int n;
            string tg;
            idx = int'(VEC[v][9:8]);
            n   = int'(VEC[v][7:0]);
            tg  = (n == 0) ? "R7" : ((idx == 0) ? "R2" : "R6");
            wr(3'(2 + idx), 16'(n));
            ctl_sh[idx] = 1'b0;
            wr(0, {13'd0, ctl_sh});
            repeat (n) @(negedge clk);
            check({tg, " held"}, {15'd0, out_of(idx)}, 16'd1);
            rd(1, d); check({tg, " status early"}, d, 16'h0000);
            @(negedge clk);
            check({tg, " released"}, {15'd0, out_of(idx)}, 16'd0);
            rd(1, d); check({tg, " status set"}, d, 16'(1 << (8 + idx)));
            ctl_sh[idx] = 1'b1;
            wr(0, {13'd0, ctl_sh});
            wr(1, 16'(1 << (8 + idx)));
        end

        // R3 R5 R4 second stage chain with early done pulse
        wr(3, 16'd4);
        ctl_sh[1] = 1'b0;
        wr(0, {13'd0, ctl_sh});
        sub_done = 1'b1;
        @(negedge clk);
        sub_done = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 por held", {15'd0, por_rst}, 16'd1);
        @(negedge clk);
        check("R3 por released", {15'd0, por_rst}, 16'd0);
        check("R3 stg2 held", {15'd0, stg2_rst}, 16'd1);
        repeat (300) @(negedge clk);
        check("R5 early done ignored", {15'd0, stg2_rst}, 16'd1);
        rd(1, d); check("R4 no status while waiting", d, 16'h0000);
        sub_done = 1'b1;
        #1;
        check("R4 held before done edge", {15'd0, stg2_rst}, 16'd1);
        @(negedge clk);
        sub_done = 1'b0;
        check("R4 stg2 released", {15'd0, stg2_rst}, 16'd0);
        rd(1, d); check("R4 status bit9", d, 16'h0200);

        // R8 re-assert second stage, R9 status stays
        ctl_sh[1] = 1'b1;
        wr(0, {13'd0, ctl_sh});
        check("R8 por reasserted", {15'd0, por_rst}, 16'd1);
        check("R8 stg2 reasserted", {15'd0, stg2_rst}, 16'd1);
        rd(1, d); check("R9 status sticky", d, 16'h0200);
        wr(1, 16'h0200);
        rd(1, d); check("R9 cleared", d, 16'h0000);

        // R10 set wins over clear on the release edge
        wr(2, 16'd3);
        ctl_sh[0] = 1'b0;
        wr(0, {13'd0, ctl_sh});
        repeat (3) @(negedge clk);
        wr(1, 16'h0100);
        check("R10 released", {15'd0, stg1_rst}, 16'd0);
        rd(1, d); check("R10 set wins", d, 16'h0100);
        wr(1, 16'h0000);
        rd(1, d); check("R9 write zero no effect", d, 16'h0100);
        wr(1, 16'h0100);
        rd(1, d); check("R9 w1c", d, 16'h0000);
        ctl_sh[0] = 1'b1;
        wr(0, {13'd0, ctl_sh});

        // R8 abort during count and full restart
        wr(2, 16'd10);
        ctl_sh[0] = 1'b0;
        wr(0, {13'd0, ctl_sh});
        repeat (3) @(negedge clk);
        ctl_sh[0] = 1'b1;
        wr(0, {13'd0, ctl_sh});
        check("R8 stg1 reasserted", {15'd0, stg1_rst}, 16'd1);
        repeat (15) @(negedge clk);
        check("R8 abort held", {15'd0, stg1_rst}, 16'd1);
        rd(1, d); check("R8 no status after abort", d, 16'h0000);
        ctl_sh[0] = 1'b0;
        wr(0, {13'd0, ctl_sh});
        repeat (10) @(negedge clk);
        check("R8 restart full count", {15'd0, stg1_rst}, 16'd1);
        @(negedge clk);
        check("R8 restart released", {15'd0, stg1_rst}, 16'd0);

        // R11 timeout rewrite during count
        wr(4, 16'd6);
        ctl_sh[2] = 1'b0;
        wr(0, {13'd0, ctl_sh});
        @(negedge clk);
        wr(4, 16'd1);
        rd(4, d); check("R11 readback", d, 16'h0001);
        repeat (4) @(negedge clk);
        check("R11 old count held", {15'd0, stg3_rst}, 16'd1);
        @(negedge clk);
        check("R11 released on old count", {15'd0, stg3_rst}, 16'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule